// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block keeps the coherence state of every line in a small direct-mapped cache that belongs to one processor in a multiprocessor. The coherence is directory based. Each line is Invalid, Shared (read only) or Exclusive (read/write). Processor reads and writes that the local state allows finish in the cycle they are presented. Any other access makes the controller send request messages to the home directory, and the processor is held off until the directory answers with a data reply.

The controller talks to the directory point to point. It uses one valid/ready message channel in each direction and does not snoop a shared bus. On the outgoing channel it sends read-miss, write-miss and data write-back messages. On the incoming channel the directory sends invalidate, fetch and fetch-with-invalidate commands, plus the data reply that ends a miss. The controller carries out these commands whenever they arrive, including while one of its own misses is still outstanding.

The block address is split into a line index (the low `IW` bits) and a tag (the remaining bits). One request is handled at a time.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `out_valid` and `cpu_done` are low, and `in_ready` is high.
- R2: A processor read whose line is Invalid or holds another tag sends one read-miss message (`out_type` 0) that carries the block address. `cpu_done` rises together with the consumed reply (`in_type` 3), with `cpu_rdata` equal to the reply data. The line is then Shared.
- R3: A processor write to a line that is Invalid, or Shared with the same tag, sends one write-miss message (`out_type` 1). After the reply, the line is Exclusive and holds the written word.
- R4: A read that hits in Shared or Exclusive, and a write that hits in Exclusive, raise `cpu_done` in the same cycle. They send no message and do not change the line state. A read returns the stored word.
- R5: An invalidate command (`in_type` 0) for a Shared line with the same tag makes the line Invalid and sends no message.
- R6: A fetch command (`in_type` 1) for an Exclusive line with the same tag sends a write-back (`out_type` 2) with the block address and the stored word, and leaves the line Shared.
- R7: A fetch-with-invalidate command (`in_type` 2) for an Exclusive line with the same tag sends a write-back with the address and data, and leaves the line Invalid.
- R8: A miss whose index holds an Exclusive line with another tag first sends that line's write-back and then the miss message, in that order. When the displaced line is only Shared, no write-back is sent.
- R9: While a miss is outstanding, `cpu_done` stays low. Directory commands are accepted and applied before the reply. While a write-back caused by a command is waiting to be sent, `in_ready` is low.
- R10: A command whose tag does not match, or whose line is in a state the command does not act on, sends no message and changes nothing.
- R11: While `out_valid` is high and `out_ready` is low, the message type, address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Block address of the request |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read word, valid with `cpu_done` |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Directory takes the outgoing message |
| out_type | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| out_addr | output | AW | Block address of the message |
| out_data | output | DW | Write-back word (0 for misses) |
| in_valid | input | 1 | Incoming directory message present |
| in_ready | output | 1 | Controller takes the incoming message |
| in_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply |
| in_addr | input | AW | Block address of the incoming message |
| in_data | input | DW | Reply data |

## Verification
The assertions assume a well-behaved processor and directory. The processor holds `cpu_valid`, `cpu_write`, `cpu_addr` and `cpu_wdata` steady until `cpu_done`. The directory sends a data reply only after the miss message has been taken, sends exactly one reply per miss, and gives it the address of the pending request. The bench keeps within these limits: its processor tasks hold the request across the whole miss, and its directory tasks issue the single reply only after every expected outgoing message has drained. Mid-miss commands target other lines. `out_ready` follows an irregular pattern throughout, so messages are also held back.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } lstate_e;

    typedef enum logic [1:0] {
        OM_RDMISS = 2'd0,
        OM_WRMISS = 2'd1,
        OM_WBACK  = 2'd2
    } omsg_e;

    typedef enum logic [1:0] {
        IC_INV      = 2'd0,
        IC_FETCH    = 2'd1,
        IC_FETCHINV = 2'd2,
        IC_REPLY    = 2'd3
    } icmd_e;

    typedef enum logic [1:0] {
        CS_IDLE      = 2'd0,
        CS_SEND_WB   = 2'd1,
        CS_SEND_MISS = 2'd2,
        CS_WAIT      = 2'd3
    } cstate_e;

    // Line state after a directory command that matched the line.
    function automatic lstate_e cmd_next_state(input icmd_e cmd, input lstate_e cur);
        lstate_e nxt;
        nxt = cur;
        case (cmd)
            IC_INV:      if (cur == LS_SHR) nxt = LS_INV;
            IC_FETCH:    if (cur == LS_EXC) nxt = LS_SHR;
            IC_FETCHINV: if (cur == LS_EXC) nxt = LS_INV;
            default:     nxt = cur;
        endcase
        return nxt;
    endfunction

    // A command forces the dirty word back to the home node.
    function automatic logic cmd_wants_wb(input icmd_e cmd, input lstate_e cur);
        return (cur == LS_EXC) && (cmd == IC_FETCH || cmd == IC_FETCHINV);
    endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int IW = 2,
    parameter int TW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_a_idx,
    output lstate_e       rd_a_state,
    output logic [TW-1:0] rd_a_tag,
    output logic [DW-1:0] rd_a_data,
    input  logic [IW-1:0] rd_b_idx,
    output lstate_e       rd_b_state,
    output logic [TW-1:0] rd_b_tag,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic          wr_full,
    input  logic [IW-1:0] wr_idx,
    input  lstate_e       wr_state,
    input  logic [TW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data
);
    localparam int LINES = 1 << IW;

    typedef struct packed {
        lstate_e       st;
        logic [TW-1:0] tag;
        logic [DW-1:0] dat;
    } line_t;

    line_t lines [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t ln_q;
        logic  sel;

        assign sel = wr_en && (wr_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ln_q.st  <= LS_INV;
                ln_q.tag <= '0;
                ln_q.dat <= '0;
            end else if (sel) begin
                ln_q.st <= wr_state;
                if (wr_full) begin
                    ln_q.tag <= wr_tag;
                    ln_q.dat <= wr_data;
                end
            end
        end

        assign lines[g] = ln_q;
    end

    always_comb begin
        rd_a_state = lines[rd_a_idx].st;
        rd_a_tag   = lines[rd_a_idx].tag;
        rd_a_data  = lines[rd_a_idx].dat;
        rd_b_state = lines[rd_b_idx].st;
        rd_b_tag   = lines[rd_b_idx].tag;
        rd_b_data  = lines[rd_b_idx].dat;
    end

endmodule

// File: rtl/coh_cmd_unit.sv
module coh_cmd_unit
    import coh_pkg::*;
#(
    parameter int TW = 6
) (
    input  icmd_e         cmd,
    input  logic [TW-1:0] cmd_tag,
    input  lstate_e       line_state,
    input  logic [TW-1:0] line_tag,
    output logic          upd,
    output lstate_e       new_state,
    output logic          need_wb
);
    logic present;

    always_comb begin
        present   = (line_state != LS_INV) && (line_tag == cmd_tag);
        new_state = cmd_next_state(cmd, line_state);
        upd       = present && (cmd != IC_REPLY) && (new_state != line_state);
        need_wb   = present && cmd_wants_wb(cmd, line_state);
    end

endmodule

// File: rtl/coh_out_sel.sv
module coh_out_sel
    import coh_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          cmd_pend,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  cstate_e       fsm,
    input  logic [AW-1:0] vic_addr,
    input  logic [DW-1:0] vic_data,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    output logic          valid,
    output omsg_e         mtype,
    output logic [AW-1:0] maddr,
    output logic [DW-1:0] mdata
);
    always_comb begin
        valid = 1'b0;
        mtype = OM_RDMISS;
        maddr = '0;
        mdata = '0;
        if (cmd_pend) begin
            valid = 1'b1;
            mtype = OM_WBACK;
            maddr = cmd_addr;
            mdata = cmd_data;
        end else if (fsm == CS_SEND_WB) begin
            valid = 1'b1;
            mtype = OM_WBACK;
            maddr = vic_addr;
            mdata = vic_data;
        end else if (fsm == CS_SEND_MISS) begin
            valid = 1'b1;
            mtype = req_write ? OM_WRMISS : OM_RDMISS;
            maddr = req_addr;
        end
    end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    input  logic          cpu_write,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [1:0]    out_type,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_type,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data
);
    localparam int TW = AW - IW;

    cstate_e       fsm_q;
    logic          req_write_q, req_upg_q;
    logic [AW-1:0] req_addr_q, vic_addr_q;
    logic [DW-1:0] req_wdata_q, vic_data_q;
    logic          cmd_pend_q;
    logic [AW-1:0] cmd_addr_q;
    logic [DW-1:0] cmd_data_q;

    // Lookup ports
    logic [IW-1:0] cpu_idx, in_idx, req_idx;
    logic [TW-1:0] cpu_tag, in_tag, req_tag;
    lstate_e       a_state, b_state;
    logic [TW-1:0] a_tag, b_tag;
    logic [DW-1:0] a_data, b_data;

    // Store write port
    logic          wr_en, wr_full;
    logic [IW-1:0] wr_idx;
    lstate_e       wr_state;
    logic [TW-1:0] wr_tag;
    logic [DW-1:0] wr_data;

    // Command decode
    icmd_e   in_cmd;
    logic    cmd_upd, cmd_wb;
    lstate_e cmd_state;

    // Outgoing message
    omsg_e   o_type;
    logic    out_fire, cmd_take, reply_take, cpu_go, a_match, a_hit;

    assign cpu_idx = cpu_addr[IW-1:0];
    assign cpu_tag = cpu_addr[AW-1:IW];
    assign in_idx  = in_addr[IW-1:0];
    assign in_tag  = in_addr[AW-1:IW];
    assign req_idx = req_addr_q[IW-1:0];
    assign req_tag = req_addr_q[AW-1:IW];
    assign in_cmd  = icmd_e'(in_type);

    coh_line_store #(.IW(IW), .TW(TW), .DW(DW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_a_idx   (cpu_idx),
        .rd_a_state (a_state),
        .rd_a_tag   (a_tag),
        .rd_a_data  (a_data),
        .rd_b_idx   (in_idx),
        .rd_b_state (b_state),
        .rd_b_tag   (b_tag),
        .rd_b_data  (b_data),
        .wr_en      (wr_en),
        .wr_full    (wr_full),
        .wr_idx     (wr_idx),
        .wr_state   (wr_state),
        .wr_tag     (wr_tag),
        .wr_data    (wr_data)
    );

    coh_cmd_unit #(.TW(TW)) u_cmd (
        .cmd        (in_cmd),
        .cmd_tag    (in_tag),
        .line_state (b_state),
        .line_tag   (b_tag),
        .upd        (cmd_upd),
        .new_state  (cmd_state),
        .need_wb    (cmd_wb)
    );

    coh_out_sel #(.AW(AW), .DW(DW)) u_out (
        .cmd_pend  (cmd_pend_q),
        .cmd_addr  (cmd_addr_q),
        .cmd_data  (cmd_data_q),
        .fsm       (fsm_q),
        .vic_addr  (vic_addr_q),
        .vic_data  (vic_data_q),
        .req_addr  (req_addr_q),
        .req_write (req_write_q),
        .valid     (out_valid),
        .mtype     (o_type),
        .maddr     (out_addr),
        .mdata     (out_data)
    );

    assign out_type = o_type;
    assign out_fire = out_valid && out_ready;

    // Inbound acceptance: only when idle or waiting, never with a queued write-back.
    assign in_ready   = !cmd_pend_q && (fsm_q == CS_IDLE || fsm_q == CS_WAIT);
    assign cmd_take   = in_valid && in_ready && (in_cmd != IC_REPLY);
    assign reply_take = in_valid && in_ready && (in_cmd == IC_REPLY) && (fsm_q == CS_WAIT);

    // Processor lookup; directory traffic goes first.
    assign cpu_go  = (fsm_q == CS_IDLE) && cpu_valid && !cmd_pend_q && !in_valid;
    assign a_match = (a_state != LS_INV) && (a_tag == cpu_tag);
    assign a_hit   = a_match && (!cpu_write || a_state == LS_EXC);

    assign cpu_done  = (cpu_go && a_hit) || reply_take;
    assign cpu_rdata = (fsm_q == CS_WAIT) ? in_data : a_data;

    // Single write port into the line store; sources are mutually exclusive by state.
    always_comb begin
        wr_en    = 1'b0;
        wr_full  = 1'b0;
        wr_idx   = cpu_idx;
        wr_state = LS_INV;
        wr_tag   = req_tag;
        wr_data  = req_wdata_q;
        if (cmd_take && cmd_upd) begin
            wr_en    = 1'b1;
            wr_idx   = in_idx;
            wr_state = cmd_state;
        end else if (cpu_go && a_hit && cpu_write) begin
            wr_en    = 1'b1;
            wr_full  = 1'b1;
            wr_idx   = cpu_idx;
            wr_state = LS_EXC;
            wr_tag   = cpu_tag;
            wr_data  = cpu_wdata;
        end else if (fsm_q == CS_SEND_WB && out_fire && !cmd_pend_q) begin
            wr_en    = 1'b1;
            wr_idx   = req_idx;
            wr_state = LS_INV;
        end else if (fsm_q == CS_SEND_MISS && out_fire && !cmd_pend_q && !req_upg_q) begin
            wr_en    = 1'b1;
            wr_idx   = req_idx;
            wr_state = LS_INV;
        end else if (reply_take) begin
            wr_en    = 1'b1;
            wr_full  = 1'b1;
            wr_idx   = req_idx;
            wr_state = req_write_q ? LS_EXC : LS_SHR;
            wr_tag   = req_tag;
            wr_data  = req_write_q ? req_wdata_q : in_data;
        end
    end

    // Request sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q       <= CS_IDLE;
            req_write_q <= 1'b0;
            req_upg_q   <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            vic_addr_q  <= '0;
            vic_data_q  <= '0;
        end else begin
            case (fsm_q)
                CS_IDLE: begin
                    if (cpu_go && !a_hit) begin
                        req_write_q <= cpu_write;
                        req_upg_q   <= a_match;
                        req_addr_q  <= cpu_addr;
                        req_wdata_q <= cpu_wdata;
                        vic_addr_q  <= {a_tag, cpu_idx};
                        vic_data_q  <= a_data;
                        fsm_q       <= (a_state == LS_EXC) ? CS_SEND_WB : CS_SEND_MISS;
                    end
                end
                CS_SEND_WB: begin
                    if (out_fire && !cmd_pend_q) fsm_q <= CS_SEND_MISS;
                end
                CS_SEND_MISS: begin
                    if (out_fire && !cmd_pend_q) fsm_q <= CS_WAIT;
                end
                CS_WAIT: begin
                    if (reply_take) fsm_q <= CS_IDLE;
                end
                default: fsm_q <= CS_IDLE;
            endcase
        end
    end

    // Write-back owed to the directory because of a command
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_pend_q <= 1'b0;
            cmd_addr_q <= '0;
            cmd_data_q <= '0;
        end else if (cmd_take && cmd_wb) begin
            cmd_pend_q <= 1'b1;
            cmd_addr_q <= in_addr;
            cmd_data_q <= b_data;
        end else if (cmd_pend_q && out_fire) begin
            cmd_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_valid,
    input logic          cpu_done,
    input logic          out_valid,
    input logic          out_ready,
    input logic [1:0]    out_type,
    input logic [AW-1:0] out_addr,
    input logic [DW-1:0] out_data,
    input logic          in_ready
);
    logic miss_out_q;

    always_ff @(posedge clk) begin
        if (rst) miss_out_q <= 1'b0;
        else if (out_valid && out_ready && out_type != 2'd2) miss_out_q <= 1'b1;
        else if (cpu_done) miss_out_q <= 1'b0;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_addr) && $stable(out_data)) // R11
        else $error("out message changed while stalled");

    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_valid) // R4
        else $error("done without request");

    AST_STALL_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !cpu_done) // R9
        else $error("done while a message is still queued");

    AST_NO_INBOUND_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready) // R9
        else $error("inbound accepted with outbound message queued");

    AST_ONE_MISS: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_type != 2'd2 |-> !miss_out_q) // R9
        else $error("second miss before reply");

    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_type != 2'd3) // R2
        else $error("illegal message type");

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_valid (cpu_valid),
    .cpu_done  (cpu_done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_type  (out_type),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .in_ready  (in_ready)
);

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [15:0] cpu_rdata;
    logic        out_valid, out_ready = 1'b1;
    logic [1:0]  out_type;
    logic [7:0]  out_addr;
    logic [15:0] out_data;
    logic        in_valid = 1'b0, in_ready;
    logic [1:0]  in_type = '0;
    logic [7:0]  in_addr = '0;
    logic [15:0] in_data = '0;

    int total = 0, bad = 0, cyc = 0;

    typedef struct {
        logic [1:0]  t;
        logic [7:0]  a;
        logic [15:0] d;
        string       rq;
    } emsg_t;
    emsg_t exp_q[$];

    // Reference line model: 0 Invalid, 1 Shared, 2 Exclusive
    int          mst [4];
    logic [5:0]  mtag[4];
    logic [15:0] mdat[4];

    coh_line_ctrl uut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
        .out_addr(out_addr), .out_data(out_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
        .in_addr(in_addr), .in_data(in_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Irregular back-pressure and watchdog
    always @(negedge clk) begin
        cyc++;
        out_ready = (cyc % 3) != 1;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            summary();
        end
    end

    // Outgoing channel compared against the model's expected messages every cycle
    always begin
        @(negedge clk);
        #2;
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected message", {6'd0, out_type, out_addr, out_data}, 32'h0);
            end else begin
                chk(out_type == exp_q[0].t && out_addr == exp_q[0].a && out_data == exp_q[0].d,
                    exp_q[0].rq, {6'd0, out_type, out_addr, out_data},
                    {6'd0, exp_q[0].t, exp_q[0].a, exp_q[0].d});
                if (out_ready) void'(exp_q.pop_front());
            end
        end
    end

    task automatic push(input logic [1:0] t, input logic [7:0] a, input logic [15:0] d, input string rq);
        emsg_t m;
        m.t = t; m.a = a; m.d = d; m.rq = rq;
        exp_q.push_back(m);
    endtask

    task automatic drain(input string rq);
        int n = 0;
        while (exp_q.size() != 0 && n < 60) begin
            @(negedge clk); #3; n++;
        end
        chk(exp_q.size() == 0, rq, exp_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    // Processor side: returns 1 on a hit; a miss leaves the request pending
    task automatic cpu_start(input bit wr, input logic [7:0] a, input logic [15:0] wd,
                             input string rq, output bit hit);
        int idx;
        logic [5:0] tg;
        bit match;
        idx = int'(a[1:0]); tg = a[7:2];
        match = mst[idx] != 0 && mtag[idx] == tg;
        hit = match && (!wr || mst[idx] == 2);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (hit) begin
            chk(cpu_done == 1'b1, {rq, " hit done"}, cpu_done, 1);
            if (!wr) chk(cpu_rdata == mdat[idx], {rq, " hit data"}, cpu_rdata, mdat[idx]);
            else mdat[idx] = wd;
            if (wr) mst[idx] = 2;
            @(negedge clk);
            cpu_valid = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            chk(cpu_done == 1'b0, {rq, " R9 stall on miss"}, cpu_done, 0);
            if (mst[idx] == 2) push(2'd2, {mtag[idx], a[1:0]}, mdat[idx], {rq, " R8 victim write-back"});
            push(wr ? 2'd1 : 2'd0, a, 16'h0, {rq, " miss message"});
            drain({rq, " miss drained"});
            chk(cpu_done == 1'b0, {rq, " R9 still stalled"}, cpu_done, 0);
            if (!(wr && match)) mst[idx] = 0;
        end
    endtask

    task automatic cpu_finish(input logic [15:0] rd, input string rq);
        int idx;
        idx = int'(cpu_addr[1:0]);
        @(negedge clk);
        in_valid = 1'b1; in_type = 2'd3; in_addr = cpu_addr; in_data = rd;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        chk(cpu_done == 1'b1, {rq, " done with reply"}, cpu_done, 1);
        if (!cpu_write) chk(cpu_rdata == rd, {rq, " reply data"}, cpu_rdata, rd);
        mst[idx]  = cpu_write ? 2 : 1;
        mtag[idx] = cpu_addr[7:2];
        mdat[idx] = cpu_write ? cpu_wdata : rd;
        @(negedge clk);
        in_valid = 1'b0; cpu_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [15:0] wd,
                          input logic [15:0] rd, input bit exp_hit, input string rq);
        bit hit;
        cpu_start(wr, a, wd, rq, hit);
        chk(hit == exp_hit, {rq, " hit/miss expectation"}, hit, exp_hit);
        if (!hit) cpu_finish(rd, rq);
    endtask

    // Directory side command; model decides the expected effect
    task automatic dir_model(input logic [1:0] c, input logic [7:0] a, input string rq);
        int idx;
        bit match;
        idx = int'(a[1:0]);
        match = mst[idx] != 0 && mtag[idx] == a[7:2];
        if (match && c == 2'd0 && mst[idx] == 1) mst[idx] = 0;
        else if (match && c == 2'd1 && mst[idx] == 2) begin push(2'd2, a, mdat[idx], rq); mst[idx] = 1; end
        else if (match && c == 2'd2 && mst[idx] == 2) begin push(2'd2, a, mdat[idx], rq); mst[idx] = 0; end
    endtask

    task automatic dir_cmd(input logic [1:0] c, input logic [7:0] a, input string rq);
        dir_model(c, a, rq);
        @(negedge clk);
        in_valid = 1'b1; in_type = c; in_addr = a; in_data = 16'hDEAD;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
        drain(rq);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = '0; mdat[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(cpu_done == 1'b0, "R1 cpu_done after reset", cpu_done, 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

        // R1 / R2: cold read misses, then hits as Shared
        cpu_op(1'b0, 8'h04, 16'h0, 16'h1111, 1'b0, "R1 R2 cold read");
        cpu_op(1'b0, 8'h04, 16'h0, 16'h0, 1'b1, "R4 read hit shared");
        // R3: upgrade from Shared
        cpu_op(1'b1, 8'h04, 16'hAAAA, 16'h1111, 1'b0, "R3 write upgrade");
        cpu_op(1'b1, 8'h04, 16'hBBBB, 16'h0, 1'b1, "R4 write hit exclusive");
        cpu_op(1'b0, 8'h04, 16'h0, 16'h0, 1'b1, "R4 read hit exclusive");
        // R6: fetch, line becomes Shared
        dir_cmd(2'd1, 8'h04, "R6 fetch write-back");
        cpu_op(1'b0, 8'h04, 16'h0, 16'h0, 1'b1, "R6 shared after fetch");
        // R5: invalidate
        dir_cmd(2'd0, 8'h04, "R5 invalidate");
        cpu_op(1'b0, 8'h04, 16'h0, 16'h2222, 1'b0, "R5 miss after invalidate");
        // R3 from Invalid, R7 fetch-invalidate
        cpu_op(1'b1, 8'h05, 16'h3333, 16'h0F0F, 1'b0, "R3 write from invalid");
        dir_cmd(2'd2, 8'h05, "R7 fetch-invalidate write-back");
        cpu_op(1'b0, 8'h05, 16'h0, 16'h4444, 1'b0, "R7 miss after fetch-invalidate");
        // R8: replacement orderings
        cpu_op(1'b1, 8'h06, 16'h5555, 16'h0, 1'b0, "R8 fill exclusive");
        cpu_op(1'b0, 8'h0A, 16'h0, 16'h6666, 1'b0, "R8 read replaces exclusive");
        cpu_op(1'b1, 8'h0E, 16'h7777, 16'h0, 1'b0, "R8 write replaces shared silently");
        cpu_op(1'b1, 8'h12, 16'h8888, 16'h0, 1'b0, "R8 write replaces exclusive");
        cpu_op(1'b0, 8'h12, 16'h0, 16'h0, 1'b1, "R8 stays exclusive");
        // R10: commands that must be ignored
        dir_cmd(2'd1, 8'h08, "R10 fetch tag mismatch");
        dir_cmd(2'd1, 8'h04, "R10 fetch on shared");
        dir_cmd(2'd0, 8'h12, "R10 invalidate on exclusive");
        dir_cmd(2'd2, 8'h07, "R10 fetch-invalidate on invalid");
        cpu_op(1'b0, 8'h04, 16'h0, 16'h0, 1'b1, "R10 shared line untouched");
        cpu_op(1'b1, 8'h12, 16'h9191, 16'h0, 1'b1, "R10 exclusive line untouched");

        // R9: command during an outstanding miss, reply held off behind its write-back
        begin
            bit hit;
            cpu_start(1'b0, 8'h07, 16'h0, "R9 pending read", hit);
            repeat (4) begin
                @(negedge clk); #1;
                chk(cpu_done == 1'b0, "R9 stall while waiting", cpu_done, 0);
            end
            dir_model(2'd1, 8'h12, "R9 fetch during miss");
            @(negedge clk);
            in_valid = 1'b1; in_type = 2'd1; in_addr = 8'h12;
            #1;
            chk(in_ready == 1'b1, "R9 command accepted while waiting", in_ready, 1);
            @(negedge clk);
            in_type = 2'd3; in_addr = 8'h07; in_data = 16'h9999;
            #1;
            chk(in_ready == 1'b0, "R9 reply held behind write-back", in_ready, 0);
            chk(cpu_done == 1'b0, "R9 no done before write-back", cpu_done, 0);
            in_valid = 1'b0;
            drain("R9 command write-back drained");
            cpu_finish(16'h9999, "R9 pending read");
        end
        cpu_op(1'b0, 8'h12, 16'h0, 16'h0, 1'b1, "R9 fetch applied, shared hit");
        cpu_op(1'b1, 8'h12, 16'hABCD, 16'h9191, 1'b0, "R9 write after fetch needs upgrade");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all messages delivered", exp_q.size(), 0);
        summary();
    end

endmodule